// File: doc/BRIEF.md
# Quadrature-Phase Time-to-Digital Converter

This block time-stamps the rising edges of an asynchronous trigger input with a resolution of a quarter of the fast clock period. The input is sampled on four copies of the fast clock, shifted by 0°, 90°, 180° and 270°. Each sample is re-timed into the 0° domain through a short synchronizer chain. A thermometer-style search over the four samples finds the first phase that saw the input high. A free-running coarse counter in the 0° domain supplies the upper part of the time value.

Each detected edge yields one word. The word holds the quarter-period time value and two status flags: one for a dropped edge and one for a coarse-counter rollover. The word is offered on a ready/valid interface. The phase clocks come from an external PLL and must be phase-locked to one another.

Top module: `qptdc_top`

## Requirements
- R1: While rstN is low, and until the first edge has been detected, tsValid is 0. An input that is high when reset ends produces no word until it has first been seen low.
- R2: Let T0 be the last rising phase-0 edge at which rstN was still low, and P the phase-0 period. For a rise at time T, the time value is ceil((T - T0)/(P/4)) modulo 2^(COARSE_W+2). It fills word bits [COARSE_W+1:0]: the coarse count is in bits [COARSE_W+1:2] and the fine code in bits [1:0].
- R3: A rise in the first, second or third quarter after a phase-0 edge gives fine code 1, 2 or 3, with the coarse count of that cycle.
- R4: A rise in the last quarter of a cycle, after the 270° sample, gives fine code 0 with the coarse count of the following cycle.
- R5: Each rise produces at most one word. An input held high for many cycles produces exactly one word.
- R6: tsValid rises just after the rising phase-0 edge at T0 + (floor(value/4) + 3)·P, where value is the time value from R2.
- R7: While tsValid is high and tsReady is low, tsValid and tsWord stay unchanged. With tsReady high, tsValid lasts one cycle per edge.
- R8: A rise detected while a word is waiting unaccepted is dropped. Bit COARSE_W+3 of the next word that is loaded is then 1; otherwise this bit is 0.
- R9: Bit COARSE_W+2 of a word is 1 exactly when the coarse counter rolled from all-ones to zero at a phase-0 edge. That edge must lie at or after the load edge of the previous word (or after reset), and before this word's load edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phaseClk | input | NPHASE (4) | Phase clocks. Bit k lags bit 0 by k quarter periods; bit 0 is the reference domain. |
| rstN | input | 1 | Asynchronous active-low reset. |
| trigIn | input | 1 | Asynchronous trigger input. |
| tsReady | input | 1 | The consumer accepts the word offered this cycle. |
| tsValid | output | 1 | A timestamp word is offered. |
| tsWord | output | COARSE_W+4 (40) | {overflow, wrap, coarse, fine}. |

## Verification
Every word comes out a fixed three phase-0 cycles after the start of the cycle that holds its first high sample. One of these cycles is the retiming hop, one is the second synchronizer flop, and one is the output register. The bench derives the time value and that load cycle from the absolute time at which it raised the input. It checks that tsValid first appears at the negative phase-0 edge just after the predicted load edge. Rises are placed 1 ns clear of every sampling edge, so the expected quarter is unambiguous. Inputs change 1 ns after a positive edge and all outputs are sampled at the negative edge, so every expected word is compared in a known cycle.

// File: rtl/qptdc_pkg.sv
`timescale 1ns/100ps
package qptdc_pkg;
  // control -> datapath strobes
  typedef struct packed {
    logic load;
    logic ovfBit;
    logic wrapBit;
  } tdcStrobe_t;

  // datapath -> control flags
  typedef struct packed {
    logic hit;
    logic cntWrap;
  } tdcFlags_t;
endpackage

// File: rtl/qptdc_sampler.sv
`timescale 1ns/100ps
module qptdc_sampler #(
  parameter int NPHASE      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic [NPHASE-1:0] phaseClk,
  input  logic              rstN,
  input  logic              trigIn,
  output logic [NPHASE-1:0] window
);
  // one capture flop per phase clock, then a chain into the phase-0 domain
  for (genvar k = 0; k < NPHASE; k++) begin : g_phase
    logic                   stageQ;
    logic [SYNC_STAGES-1:0] chainQ;

    always_ff @(posedge phaseClk[k]) begin
      stageQ <= trigIn;
    end

    // reset to ones so that nothing looks like a rise right after reset
    always_ff @(posedge phaseClk[0] or negedge rstN) begin
      if (!rstN) chainQ <= '1;
      else       chainQ <= {chainQ[SYNC_STAGES-2:0], stageQ};
    end

    assign window[k] = chainQ[SYNC_STAGES-1];
  end
endmodule

// File: rtl/qptdc_datapath.sv
`timescale 1ns/100ps
module qptdc_datapath
  import qptdc_pkg::*;
#(
  parameter int COARSE_W    = 36,
  parameter int NPHASE      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int FINE_W     = $clog2(NPHASE),
  localparam int WORD_W     = COARSE_W + FINE_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NPHASE-1:0] window,
  input  tdcStrobe_t        ctl,
  output tdcFlags_t         flags,
  output logic [WORD_W-1:0] wordQ
);
  logic [COARSE_W-1:0] coarseCnt;
  logic                lastLevel;
  logic [NPHASE-1:0]   prevVec;
  logic [NPHASE-1:0]   riseVec;
  logic [FINE_W-1:0]   firstIdx;
  logic [COARSE_W-1:0] stampCoarse;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) coarseCnt <= '0;
    else       coarseCnt <= coarseCnt + 1'b1;
  end

  // level of the final sample of the previous window; ones after reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastLevel <= 1'b1;
    else       lastLevel <= window[NPHASE-1];
  end

  // a rise at phase k: sample k high, the sample before it low
  assign prevVec = {window[NPHASE-2:0], lastLevel};
  assign riseVec = window & ~prevVec;

  always_comb begin
    firstIdx = '0;
    for (int k = NPHASE - 1; k >= 0; k--) begin
      if (riseVec[k]) firstIdx = FINE_W'(k);
    end
  end

  // the window under test started SYNC_STAGES cycles before the counter
  assign stampCoarse = coarseCnt - COARSE_W'(SYNC_STAGES);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         wordQ <= '0;
    else if (ctl.load) wordQ <= {ctl.ovfBit, ctl.wrapBit, stampCoarse, firstIdx};
  end

  assign flags.hit     = |riseVec;
  assign flags.cntWrap = &coarseCnt;

  AST_COARSE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> coarseCnt == COARSE_W'($past(coarseCnt) + 1'b1)); // R2

  AST_HELD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (lastLevel && (&window)) |-> !flags.hit); // R5
endmodule

// File: rtl/qptdc_control.sv
`timescale 1ns/100ps
module qptdc_control
  import qptdc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  tdcFlags_t  flags,
  input  logic       tsReady,
  output logic       tsValid,
  output tdcStrobe_t ctl
);
  logic validQ;
  logic ovfPend;
  logic wrapPend;
  logic canLoad;
  logic load;

  assign canLoad = !validQ || tsReady;
  assign load    = flags.hit && canLoad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        validQ <= 1'b0;
    else if (load)    validQ <= 1'b1;
    else if (tsReady) validQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      ovfPend <= 1'b0;
    else if (load)                  ovfPend <= 1'b0;
    else if (flags.hit && !canLoad) ovfPend <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              wrapPend <= 1'b0;
    else if (load)          wrapPend <= flags.cntWrap;
    else if (flags.cntWrap) wrapPend <= 1'b1;
  end

  assign ctl.load    = load;
  assign ctl.ovfBit  = ovfPend;
  assign ctl.wrapBit = wrapPend;
  assign tsValid     = validQ;

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (validQ && !tsReady) |=> validQ); // R7

  AST_HIT_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    (flags.hit && (!validQ || tsReady)) |=> validQ); // R6

  AST_OVF_ON_DROP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfPend) |-> $past(flags.hit && validQ && !tsReady)); // R8

  AST_WRAP_CATCH: assert property (@(posedge clk) disable iff (!rstN)
    flags.cntWrap |=> wrapPend); // R9
endmodule

// File: rtl/qptdc_top.sv
`timescale 1ns/100ps
module qptdc_top
  import qptdc_pkg::*;
#(
  parameter int COARSE_W    = 36,
  parameter int NPHASE      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int FINE_W     = $clog2(NPHASE),
  localparam int WORD_W     = COARSE_W + FINE_W + 2
) (
  input  logic [NPHASE-1:0] phaseClk,
  input  logic              rstN,
  input  logic              trigIn,
  input  logic              tsReady,
  output logic              tsValid,
  output logic [WORD_W-1:0] tsWord
);
  logic [NPHASE-1:0] window;
  tdcStrobe_t        ctl;
  tdcFlags_t         flags;

  qptdc_sampler #(.NPHASE(NPHASE), .SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .phaseClk (phaseClk),
    .rstN     (rstN),
    .trigIn   (trigIn),
    .window   (window)
  );

  qptdc_datapath #(.COARSE_W(COARSE_W), .NPHASE(NPHASE), .SYNC_STAGES(SYNC_STAGES)) u_datapath (
    .clk    (phaseClk[0]),
    .rstN   (rstN),
    .window (window),
    .ctl    (ctl),
    .flags  (flags),
    .wordQ  (tsWord)
  );

  qptdc_control u_control (
    .clk     (phaseClk[0]),
    .rstN    (rstN),
    .flags   (flags),
    .tsReady (tsReady),
    .tsValid (tsValid),
    .ctl     (ctl)
  );

  AST_WORD_STABLE: assert property (@(posedge phaseClk[0]) disable iff (!rstN)
    (tsValid && !tsReady) |=> $stable(tsWord)); // R7
endmodule

// File: tb/qptdc_top_bench.sv
`timescale 1ns/100ps
module qptdc_top_bench;
  localparam int  CW = 10;
  localparam int  WW = CW + 4;
  localparam real T0 = 995.0;

  typedef struct {
    logic [WW-1:0] word;
    longint        loadCyc;
    string         req;
  } expItem_t;

  logic ph0 = 0, ph1 = 0, ph2 = 0, ph3 = 0;
  logic rstN = 0, trigIn = 1, tsReady = 1;
  logic          tsValid;
  logic [WW-1:0] tsWord;

  expItem_t expQ[$];
  int       nChecks = 0, nFails = 0;
  bit       done = 0;
  longint   prevL = 1;
  bit       ovfFlag = 0;
  bit       seenCur = 0, afterAcc = 0;

  initial forever #5 ph0 = ~ph0;
  initial begin #2.5; forever #5 ph1 = ~ph1; end
  initial begin #5.0; forever #5 ph2 = ~ph2; end
  initial begin #7.5; forever #5 ph3 = ~ph3; end

  qptdc_top #(.COARSE_W(CW)) u_qptdc_top (
    .phaseClk ({ph3, ph2, ph1, ph0}),
    .rstN     (rstN),
    .trigIn   (trigIn),
    .tsReady  (tsReady),
    .tsValid  (tsValid),
    .tsWord   (tsWord)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $realtime);
    end
  endtask

  task automatic waitUntil(input real t);
    if (t > $realtime) #(t - $realtime);
  endtask

  // rise at T0 + cyc*P + off10/10 ns; expected word pushed when it is loaded
  task automatic riseAt(input longint cyc, input int off10, input int highCyc,
                        input bit loads, input string req);
    longint   d10, ts, win, lcyc;
    bit       wrap;
    expItem_t it;
    d10  = cyc * 100 + off10;
    ts   = (d10 + 24) / 25;
    win  = ts >>> 2;
    lcyc = win + 3;
    if (loads) begin
      wrap = ((lcyc - 1) >>> CW) != ((prevL - 1) >>> CW);
      it.word    = {ovfFlag, wrap, ts[CW+1:0]};
      it.loadCyc = lcyc;
      it.req     = req;
      expQ.push_back(it);
      prevL   = lcyc;
      ovfFlag = 0;
    end else begin
      ovfFlag = 1;
    end
    waitUntil(T0 + cyc * 10.0 + off10 / 10.0);
    trigIn = 1;
    #(highCyc * 10.0);
    trigIn = 0;
  endtask

  task automatic setReady(input longint cyc, input logic v);
    waitUntil(T0 + cyc * 10.0 + 1.0);
    tsReady = v;
  endtask

  // monitor / scoreboard
  always @(negedge ph0) begin
    longint curCyc;
    bit     newDue;
    if (rstN) begin
      curCyc = longint'($rtoi(($realtime - T0 - 5.0) / 10.0 + 0.5));
      if (afterAcc) begin
        newDue = expQ.size() > 0 && expQ[0].loadCyc == curCyc;
        check(tsValid == newDue, "R7", "valid after accept", tsValid, newDue);
        afterAcc = 0;
      end
      if (tsValid) begin
        if (!seenCur) begin
          seenCur = 1;
          if (expQ.size() == 0) check(0, "R5", "unexpected word", tsWord, 0);
          else check(curCyc == expQ[0].loadCyc, "R6", "valid cycle", curCyc, expQ[0].loadCyc);
        end
        if (expQ.size() > 0) begin
          if (tsReady) begin
            check(tsWord == expQ[0].word, expQ[0].req, "word", tsWord, expQ[0].word);
            void'(expQ.pop_front());
            seenCur  = 0;
            afterAcc = 1;
          end else begin
            check(tsWord == expQ[0].word, "R7", "held word", tsWord, expQ[0].word);
          end
        end else if (tsReady) begin
          seenCur = 0;
        end
      end
    end
  end

  initial begin
    #(200000 * 10.0);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #500;
    check(tsValid == 0, "R1", "valid in reset", tsValid, 0);
    waitUntil(1001.0);
    rstN = 1;
    // input held high through reset, dropped at cycle 20: no word (R1)
    waitUntil(T0 + 201.0);
    trigIn = 0;
    waitUntil(T0 + 355.0);
    check(tsValid == 0, "R1", "no word for high-at-reset", tsValid, 0);

    riseAt(50, 10, 5, 1, "R3");   // first quarter -> fine 1
    riseAt(60, 35, 5, 1, "R3");   // second quarter -> fine 2
    riseAt(70, 60, 5, 1, "R3");   // third quarter -> fine 3
    riseAt(80, 85, 5, 1, "R4");   // last quarter -> next coarse, fine 0
    riseAt(100, 35, 60, 1, "R5"); // held high: one word only
    for (int i = 0; i < 16; i++)
      riseAt(200 + 7 * i, 10 + 25 * (i % 4), 3, 1, "R2");

    setReady(400, 0);
    riseAt(410, 10, 3, 1, "R7");  // loaded and held
    riseAt(420, 35, 3, 0, "R8");  // dropped
    riseAt(430, 60, 3, 0, "R8");  // dropped
    setReady(450, 1);
    riseAt(460, 85, 3, 1, "R8");  // carries overflow flag
    riseAt(470, 10, 3, 1, "R8");  // flag cleared

    riseAt(1000, 35, 3, 1, "R9");
    riseAt(1023, 85, 3, 1, "R9"); // value wraps to 0, rollover before load
    riseAt(1030, 10, 3, 1, "R9");
    riseAt(1040, 60, 3, 1, "R9");

    waitUntil(T0 + 1100 * 10.0);
    check(expQ.size() == 0, "R5", "words outstanding", expQ.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule